// File: doc/BRIEF.md
# Self-Correcting Ten-State Twisted-Ring Counter

This block counts in a five-stage twisted-ring (Johnson) register that cycles through ten legal codes. Each code is decoded to its own active-high output, so exactly one of ten lines is high at any time. An active-low carry is low for the upper half of the count (states 5 to 9). It goes high again when the count wraps from 9 to 0, so it can feed the rising-edge count input of a following counter.

Two count inputs step the counter. `cnt_rise` steps it on a rising edge while `cnt_fall` is low. `cnt_fall` steps it on a falling edge while `cnt_rise` is high. Each input therefore acts as an enable for the other. Both inputs are brought onto the system clock through a two-flop synchroniser, and their edges are found there. The master reset `mr` is asynchronous: it forces state 0 at once and overrides all counting. If the register ever holds one of the 22 codes outside the ten-state ring, the next-state function returns it to the ring well within the eleven-step limit.

Top module: `johnson_decade`

## Requirements
- R1: After reset the count visits states 0,1,2,...,9 in order, one step per qualifying edge, and wraps from 9 to 0.
- R2: `dec_out[k]` is high exactly when the state is k. Exactly one bit of `dec_out` is high at all times.
- R3: A rising edge on `cnt_rise` advances the count by one while `cnt_fall` is low. While `cnt_fall` is high, the same edge is ignored.
- R4: A falling edge on `cnt_fall` advances the count by one while `cnt_rise` is high. While `cnt_rise` is low, the same edge is ignored.
- R5: `carry_n` is 0 in states 5 to 9 and 1 in states 0 to 4, so it rises on the 9-to-0 wrap.
- R6: An input change first sampled at clock edge n shows on the outputs after clock edge n+2, and not before.
- R7: While `mr` is 1, the state is 0 (`dec_out` = 10'b0000000001, `carry_n` = 1). This takes effect without waiting for a clock edge. An edge already in the synchroniser when `mr` is active is discarded.
- R8: The next-state function maps each legal state k to state (k+1) mod 10. It brings each of the 22 illegal five-bit codes into the legal ring within 11 steps.
- R9: A rising `cnt_rise` and a falling `cnt_fall` that reach the counter in the same cycle advance it by one, not two.
- R10: With no qualifying edge, the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both count inputs are sampled on its rising edge |
| mr | input | 1 | Asynchronous master reset, active high, forces state 0 |
| cnt_rise | input | 1 | Count input stepping on its rising edge while `cnt_fall` is low |
| cnt_fall | input | 1 | Count input stepping on its falling edge while `cnt_rise` is high |
| dec_out | output | 10 | One-hot decoded state, bit k high in state k |
| carry_n | output | 1 | Active-low carry, low in states 5 to 9 |

## Verification
Two pairs of functions can land in the same clock cycle. The first pair is the two count edges. The bench provokes this by raising `cnt_rise` and dropping `cnt_fall` in the same cycle, and it requires exactly one step. The second pair is the master reset and a count edge that is already in the synchroniser. The bench asserts `mr` in the cycle the pending step would take effect and releases it one cycle later. It requires state 0 afterwards with no late step. A behavioural model in the bench, kept in queues of sampled inputs, is compared with the outputs on every clock.

// File: rtl/jdc_pkg.sv
`timescale 1ns/1ps
package jdc_pkg;

    localparam int JDC_STAGES = 5;
    localparam int JDC_STATES = 2 * JDC_STAGES;

    typedef logic [JDC_STAGES-1:0] ring_t;
    typedef logic [JDC_STATES-1:0] dec_t;

    typedef struct packed {
        logic up;    // rising-edge count input
        logic dn;    // falling-edge count input
    } pins_t;

    // Legal ring code for state k: ones fill from bit 0, then zeros fill from bit 0.
    function automatic ring_t ring_code(input int k);
        ring_t ones;
        ones = '1;
        if (k < JDC_STAGES)
            return ring_t'((1 << k) - 1);
        return ones & ~ring_t'((1 << (k - JDC_STAGES)) - 1);
    endfunction

    function automatic logic ring_legal(input ring_t r);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < JDC_STATES; k++)
            if (r == ring_code(k)) hit = 1'b1;
        return hit;
    endfunction

    // Twisted shift for legal codes; any illegal code folds to state 0.
    function automatic ring_t ring_next(input ring_t r);
        if (ring_legal(r))
            return {r[JDC_STAGES-2:0], ~r[JDC_STAGES-1]};
        return '0;
    endfunction

endpackage

// File: rtl/jdc_edge.sv
`timescale 1ns/1ps
module jdc_edge
    import jdc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  pins_t pin_i,
    output logic  step_o
);
    localparam int CHAIN = SYNC_STAGES + 1;

    pins_t [CHAIN-1:0] chain;
    pins_t lvl, prev;
    logic  up_edge, dn_edge;

    always_ff @(posedge clk) begin
        chain <= {chain[CHAIN-2:0], pin_i};
    end

    assign lvl  = chain[CHAIN-2];
    assign prev = chain[CHAIN-1];

    // Each input qualifies the other's edge.
    assign up_edge = lvl.up & ~prev.up & ~lvl.dn;
    assign dn_edge = ~lvl.dn & prev.dn & lvl.up;
    assign step_o  = up_edge | dn_edge;

endmodule

// File: rtl/jdc_ring.sv
`timescale 1ns/1ps
module jdc_ring
    import jdc_pkg::*;
(
    input  logic  clk,
    input  logic  mr,
    input  logic  step,
    output ring_t ring_o
);
    ring_t ring_q;

    always_ff @(posedge clk or posedge mr) begin
        if (mr)
            ring_q <= '0;
        else if (step)
            ring_q <= ring_next(ring_q);
    end

    assign ring_o = ring_q;

    // R1: each step moves exactly one place along the ring
    a_r1_one_place: assert property (@(posedge clk) disable iff (mr)
        step |=> (ring_q == ring_next($past(ring_q))));

    // R10: no step, no change
    a_r10_hold: assert property (@(posedge clk) disable iff (mr)
        !step |=> $stable(ring_q));

    // R8: the register never leaves the legal ring after reset
    a_r8_legal: assert property (@(posedge clk) disable iff (mr)
        ring_legal(ring_q));

    // R7: master reset pins the register to zero
    a_r7_clear: assert property (@(posedge clk)
        mr |-> (ring_q == '0));

endmodule

// File: rtl/jdc_decode.sv
`timescale 1ns/1ps
module jdc_decode
    import jdc_pkg::*;
(
    input  ring_t ring_i,
    output dec_t  dec_o,
    output logic  carry_n_o
);
    localparam int S = JDC_STAGES;

    for (genvar k = 0; k < JDC_STATES; k++) begin : g_dec
        if (k == 0) begin : g_lo_end
            assign dec_o[k] = ~ring_i[S-1] & ~ring_i[0];
        end else if (k < S) begin : g_fill
            assign dec_o[k] = ring_i[k-1] & ~ring_i[k];
        end else if (k == S) begin : g_hi_end
            assign dec_o[k] = ring_i[S-1] & ring_i[0];
        end else begin : g_drain
            assign dec_o[k] = ~ring_i[k-S-1] & ring_i[k-S];
        end
    end

    assign carry_n_o = ~ring_i[S-1];

endmodule

// File: rtl/johnson_decade.sv
`timescale 1ns/1ps
module johnson_decade
    import jdc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  mr,
    input  logic                  cnt_rise,
    input  logic                  cnt_fall,
    output logic [JDC_STATES-1:0] dec_out,
    output logic                  carry_n
);
    pins_t pins;
    logic  step;
    ring_t ring;

    assign pins.up = cnt_rise;
    assign pins.dn = cnt_fall;

    jdc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .pin_i  (pins),
        .step_o (step)
    );

    jdc_ring u_ring (
        .clk    (clk),
        .mr     (mr),
        .step   (step),
        .ring_o (ring)
    );

    jdc_decode u_dec (
        .ring_i    (ring),
        .dec_o     (dec_out),
        .carry_n_o (carry_n)
    );

    // R2: one-hot decode
    a_r2_onehot: assert property (@(posedge clk) disable iff (mr)
        $countones(dec_out) == 1);

    // R5: carry low exactly in the upper five states
    a_r5_carry: assert property (@(posedge clk) disable iff (mr)
        carry_n == !(|dec_out[JDC_STATES-1:JDC_STAGES]));

    // R7: reset state seen at the ports
    a_r7_port_zero: assert property (@(posedge clk)
        mr |-> (dec_out[0] && carry_n));

endmodule

// File: tb/johnson_decade_tb.sv
`timescale 1ns/1ps
module johnson_decade_tb;
    import jdc_pkg::*;

    logic       clk = 1'b0;
    logic       mr = 1'b1;
    logic       cnt_rise = 1'b0;
    logic       cnt_fall = 1'b0;
    logic [9:0] dec_out;
    logic       carry_n;

    int checks = 0;
    int errors = 0;
    int exp_state = 0;
    bit live_check = 1'b0;
    bit q_up[$];
    bit q_dn[$];

    always #5 clk = ~clk;

    johnson_decade u_dut (
        .clk(clk), .mr(mr), .cnt_rise(cnt_rise), .cnt_fall(cnt_fall),
        .dec_out(dec_out), .carry_n(carry_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int idx(input logic [9:0] d);
        int r;
        r = -1;
        if ($countones(d) == 1)
            for (int k = 0; k < 10; k++) if (d[k]) r = k;
        return r;
    endfunction

    // Behavioural reference: inputs reach the counter two samples late.
    always @(posedge clk) begin
        bit up_c, up_p, dn_c, dn_p, adv;
        adv = 1'b0;
        if (q_up.size() >= 3) begin
            up_c = q_up[q_up.size()-2]; up_p = q_up[q_up.size()-3];
            dn_c = q_dn[q_dn.size()-2]; dn_p = q_dn[q_dn.size()-3];
            adv = (up_c && !up_p && !dn_c) || (dn_p && !dn_c && up_c);
        end
        if (mr) exp_state = 0;
        else if (adv) exp_state = (exp_state + 1) % 10;
        q_up.push_back(cnt_rise);
        q_dn.push_back(cnt_fall);
        if (q_up.size() > 4) begin
            void'(q_up.pop_front());
            void'(q_dn.pop_front());
        end
    end

    always @(posedge mr) exp_state = 0;

    always @(negedge clk) begin
        if (live_check) begin
            chk(idx(dec_out) == exp_state, "R1/R2 model", idx(dec_out), exp_state);
            chk(carry_n == (exp_state < 5), "R5 model", carry_n, exp_state < 5);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_up();
        cnt_rise = 1'b1; tick(4);
        cnt_rise = 1'b0; tick(4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        ring_t r;
        int    illegal;
        int    steps;
        bit    legal_tab[32];

        tick(4);
        live_check = 1'b1;
        @(negedge clk);
        chk(idx(dec_out) == 0 && carry_n, "R7 reset state", idx(dec_out), 0);
        tick(1);
        mr = 1'b0;
        tick(4);

        // R1 / R3 / R5: rising-edge counting through a wrap
        for (int i = 1; i <= 12; i++) begin
            pulse_up();
            chk(idx(dec_out) == i % 10, "R3 count", idx(dec_out), i % 10);
            chk(carry_n == ((i % 10) < 5), "R5 carry", carry_n, (i % 10) < 5);
        end

        // R3 ignored: rising cnt_rise while cnt_fall high
        cnt_fall = 1'b1; tick(4);
        chk(idx(dec_out) == 2, "R4 dn rising no step", idx(dec_out), 2);
        pulse_up();
        chk(idx(dec_out) == 2, "R3 blocked by dn high", idx(dec_out), 2);
        // R4 ignored: falling cnt_fall while cnt_rise low
        cnt_fall = 1'b0; tick(4);
        chk(idx(dec_out) == 2, "R4 blocked by up low", idx(dec_out), 2);

        // R4 counting: arm cnt_rise while cnt_fall high, then toggle cnt_fall
        cnt_fall = 1'b1; tick(4);
        cnt_rise = 1'b1; tick(4);
        chk(idx(dec_out) == 2, "R3 arm no step", idx(dec_out), 2);
        for (int i = 1; i <= 10; i++) begin
            cnt_fall = 1'b0; tick(4);
            chk(idx(dec_out) == (2 + i) % 10, "R4 count", idx(dec_out), (2 + i) % 10);
            cnt_fall = 1'b1; tick(4);
            chk(idx(dec_out) == (2 + i) % 10, "R10 hold", idx(dec_out), (2 + i) % 10);
        end

        // R9: both qualifying edges in one cycle
        cnt_rise = 1'b0; tick(4);
        chk(idx(dec_out) == 2, "R10 up falling no step", idx(dec_out), 2);
        cnt_rise = 1'b1; cnt_fall = 1'b0; tick(6);
        chk(idx(dec_out) == 3, "R9 single step", idx(dec_out), 3);

        // R6: latency of the synchroniser
        cnt_rise = 1'b0; tick(4);
        cnt_rise = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(idx(dec_out) == 3, "R6 not before n+2", idx(dec_out), 3);
        @(negedge clk);
        chk(idx(dec_out) == 4, "R6 at n+2", idx(dec_out), 4);
        tick(4);

        // R7: asynchronous effect mid-cycle
        @(posedge clk); #3;
        mr = 1'b1; #1;
        chk(idx(dec_out) == 0, "R7 async clear", idx(dec_out), 0);
        tick(2);
        mr = 1'b0; tick(3);
        chk(idx(dec_out) == 0, "R7 after release", idx(dec_out), 0);

        // R7: pending edge swallowed by reset
        cnt_rise = 1'b0; tick(4);
        cnt_rise = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        mr = 1'b1;
        @(posedge clk); #2;
        mr = 1'b0;
        tick(4);
        chk(idx(dec_out) == 0, "R7 pending edge dropped", idx(dec_out), 0);
        cnt_rise = 1'b0; tick(4);
        pulse_up();
        chk(idx(dec_out) == 1, "R1 resume after reset", idx(dec_out), 1);

        // R8: next-state function over all 32 codes
        for (int c = 0; c < 32; c++) legal_tab[c] = 1'b0;
        r = '0;
        for (int k = 0; k < 10; k++) begin
            legal_tab[r] = 1'b1;
            r = {r[3:0], ~r[4]};
        end
        r = '0;
        for (int k = 0; k < 10; k++) begin
            ring_t nx;
            ring_t want;
            want = {r[3:0], ~r[4]};
            nx = ring_next(r);
            chk(nx == want, "R8 legal successor", nx, want);
            r = want;
        end
        illegal = 0;
        for (int c = 0; c < 32; c++) begin
            if (!legal_tab[c]) begin
                illegal++;
                r = ring_t'(c);
                steps = 0;
                while (!legal_tab[r] && steps < 12) begin
                    r = ring_next(r);
                    steps++;
                end
                chk(legal_tab[r] && steps <= 11, "R8 illegal converges", steps, 11);
            end
        end
        chk(illegal == 22, "R8 illegal count", illegal, 22);

        tick(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule